// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small pool of waiting slots that sits in front of one class of functional unit in an out-of-order core. An issued instruction lands in a free slot with its operation code, the reorder tag that will receive its result, and two operands. Each operand arrives either as a value or as the reorder tag of the instruction that will produce it. A slot that is still missing an operand watches the result broadcast bus. When the bus shows the tag it waits for, the slot copies the value.

Once both operands of a slot hold values, the slot may go to the unit. When several slots qualify, the one nearest the head of the reorder window goes first. At most one slot leaves per cycle, and it is freed in the cycle it is handed over, not when the unit finishes. A flush input drops every slot younger than a given reorder tag, which is how the core recovers from a mispredicted branch.

Top module: `tag_rs`

## Requirements
- R1: After reset every slot is empty and `disp_valid` is low.
- R2: `iss_accept` is high only when `iss_valid` and `rob_free` are both high, at least one slot is empty and `flush_valid` is low. When it is high the request is written into a slot at the next clock edge.
- R3: An operand issued with its ready flag high is stored as the given value. Its tag input and any broadcast carrying that tag do not change it.
- R4: A waiting operand takes `cdb_val` at the first edge where `cdb_valid` is high and `cdb_tag` equals its producer tag. Broadcasts with other tags leave it waiting.
- R5: A broadcast in the same cycle as the issue of an instruction waiting on that tag is captured by the new slot. This holds for both operands, including when both wait on the same tag.
- R6: A slot drives `disp_valid` only when both of its operands hold values. While it is selected, `disp_op`, `disp_a`, `disp_b` and `disp_dest` carry its operation, operand A, operand B and destination tag.
- R7: Among ready slots the one with the smallest age is selected, where age is (`disp_dest` minus `rob_head`) modulo 2^TAG_W. Only one slot is presented per cycle.
- R8: A slot is freed at the edge where `disp_valid` and `fu_ready` are both high. While `fu_ready` is low it stays presented and occupied.
- R9: While `flush_valid` is high, `disp_valid` and `iss_accept` are low. At that edge every slot whose destination age is greater than the age of `flush_tag` is emptied, and older slots are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_op | input | OP_W | Operation code of the request |
| iss_dest | input | TAG_W | Reorder tag that will receive the result |
| iss_a_rdy | input | 1 | Operand A given as a value |
| iss_a_val | input | DATA_W | Operand A value |
| iss_a_tag | input | TAG_W | Producer tag of operand A when not ready |
| iss_b_rdy | input | 1 | Operand B given as a value |
| iss_b_val | input | DATA_W | Operand B value |
| iss_b_tag | input | TAG_W | Producer tag of operand B when not ready |
| rob_free | input | 1 | A reorder entry is available for this request |
| iss_accept | output | 1 | Request taken this cycle |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Broadcast result value |
| rob_head | input | TAG_W | Tag of the oldest reorder entry |
| flush_valid | input | 1 | Squash request |
| flush_tag | input | TAG_W | Youngest tag that survives the squash |
| fu_ready | input | 1 | Functional unit takes the presented slot |
| disp_valid | output | 1 | A ready slot is presented |
| disp_op | output | OP_W | Operation of the presented slot |
| disp_a | output | DATA_W | Operand A of the presented slot |
| disp_b | output | DATA_W | Operand B of the presented slot |
| disp_dest | output | TAG_W | Destination tag of the presented slot |

## Verification
Single instructions are issued into an empty station with operands that are ready, waiting on one tag, waiting on two different tags or waiting on the same tag. Broadcasts are sent in the issue cycle, in the following cycle, with unrelated tags, or aimed at an operand that was already ready. These cases separate capture at issue from capture while waiting, and show whether matching honours the ready flag. Directed sequences fill the pool to check the stall, and drain it with the reorder head placed so that tag order and age order differ, which exposes selection by raw tag. A flush at a middle tag shows whether the boundary entry itself is kept.

// File: rtl/tag_rs.sv
module tag_rs #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 3,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dest,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic              rob_free,
  output logic              iss_accept,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  input  logic [TAG_W-1:0]  rob_head,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic              fu_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_dest
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] busy, a_has, b_has, ready;
  logic [OP_W-1:0]    op_q  [ENTRIES];
  logic [TAG_W-1:0]   dst_q [ENTRIES];
  logic [TAG_W-1:0]   a_tag [ENTRIES];
  logic [TAG_W-1:0]   b_tag [ENTRIES];
  logic [DATA_W-1:0]  a_val [ENTRIES];
  logic [DATA_W-1:0]  b_val [ENTRIES];

  logic [IDX_W-1:0] free_idx, sel_idx;
  logic [TAG_W-1:0] best_age, fl_age;
  logic             sel_any, fire;

  function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] t);
    return t - rob_head;
  endfunction

  assign ready      = busy & a_has & b_has;
  assign fl_age     = age_of(flush_tag);
  assign iss_accept = iss_valid & rob_free & ~flush_valid & ~&busy;
  assign disp_valid = sel_any & ~flush_valid;
  assign fire       = disp_valid & fu_ready;
  assign disp_op    = op_q[sel_idx];
  assign disp_a     = a_val[sel_idx];
  assign disp_b     = b_val[sel_idx];
  assign disp_dest  = dst_q[sel_idx];

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    sel_any  = 1'b0;
    sel_idx  = '0;
    best_age = '1;
    for (int i = 0; i < ENTRIES; i++)
      if (ready[i] && (!sel_any || age_of(dst_q[i]) < best_age)) begin
        sel_any  = 1'b1;
        sel_idx  = IDX_W'(i);
        best_age = age_of(dst_q[i]);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      a_has <= '0;
      b_has <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (busy[i] && !a_has[i] && cdb_valid && cdb_tag == a_tag[i]) begin
          a_has[i] <= 1'b1;
          a_val[i] <= cdb_val;
        end
        if (busy[i] && !b_has[i] && cdb_valid && cdb_tag == b_tag[i]) begin
          b_has[i] <= 1'b1;
          b_val[i] <= cdb_val;
        end
        if (fire && sel_idx == IDX_W'(i)) busy[i] <= 1'b0;
        if (flush_valid && age_of(dst_q[i]) > fl_age) busy[i] <= 1'b0;
        if (iss_accept && free_idx == IDX_W'(i)) begin
          busy[i]  <= 1'b1;
          op_q[i]  <= iss_op;
          dst_q[i] <= iss_dest;
          a_tag[i] <= iss_a_tag;
          b_tag[i] <= iss_b_tag;
          a_has[i] <= iss_a_rdy | (cdb_valid & cdb_tag == iss_a_tag);
          b_has[i] <= iss_b_rdy | (cdb_valid & cdb_tag == iss_b_tag);
          a_val[i] <= iss_a_rdy ? iss_a_val : cdb_val;
          b_val[i] <= iss_b_rdy ? iss_b_val : cdb_val;
        end
      end
    end
  end
endmodule

// File: rtl/tag_rs_chk.sv
module tag_rs_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rob_free,
  input logic               iss_accept,
  input logic               flush_valid,
  input logic               fu_ready,
  input logic               disp_valid,
  input logic [ENTRIES-1:0] busy
);
  // R2
  rob_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |-> rob_free);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |-> $countones(busy) < ENTRIES);

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_valid |=> $countones(busy) ==
      $past($countones(busy)) + int'($past(iss_accept)) - int'($past(disp_valid && fu_ready)));

  // R9
  flush_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> $countones(busy) <= $past($countones(busy)));

  // R6
  disp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> busy != '0);
endmodule

bind tag_rs tag_rs_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rob_free(rob_free), .iss_accept(iss_accept),
  .flush_valid(flush_valid), .fu_ready(fu_ready), .disp_valid(disp_valid),
  .busy(busy)
);

// File: tb/tag_rs_bench.sv
module tag_rs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, iss_a_rdy = 1'b0, iss_b_rdy = 1'b0, rob_free = 1'b1;
  logic [2:0]  iss_op = '0, iss_dest = '0, iss_a_tag = '0, iss_b_tag = '0;
  logic [15:0] iss_a_val = '0, iss_b_val = '0;
  logic        cdb_valid = 1'b0, flush_valid = 1'b0, fu_ready = 1'b0;
  logic [2:0]  cdb_tag = '0, rob_head = '0, flush_tag = '0;
  logic [15:0] cdb_val = '0;
  logic        iss_accept, disp_valid;
  logic [2:0]  disp_op, disp_dest;
  logic [15:0] disp_a, disp_b;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  tag_rs u_tag_rs (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dest(iss_dest),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .rob_free(rob_free), .iss_accept(iss_accept), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_val(cdb_val), .rob_head(rob_head), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
    .disp_b(disp_b), .disp_dest(disp_dest)
  );

  typedef struct packed {
    logic ar; logic [15:0] av; logic [2:0] at;
    logic br; logic [15:0] bv; logic [2:0] bt;
    logic c1v; logic [2:0] c1t; logic [15:0] c1d;
    logic c2v; logic [2:0] c2t; logic [15:0] c2d;
    logic [2:0] op; logic [2:0] dst;
    logic xv; logic [15:0] xa; logic [15:0] xb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 16'h1111, 3'd0, 1'b1, 16'h2222, 3'd0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 3'd1, 3'd1, 1'b1, 16'h1111, 16'h2222},
    '{1'b0, 16'h0, 3'd5, 1'b1, 16'h0B0B, 3'd0, 1'b0, 3'd0, 16'h0, 1'b1, 3'd5, 16'hAAAA, 3'd2, 3'd2, 1'b1, 16'hAAAA, 16'h0B0B},
    '{1'b0, 16'h0, 3'd5, 1'b1, 16'h0C0C, 3'd0, 1'b1, 3'd5, 16'h5A5A, 1'b0, 3'd0, 16'h0, 3'd3, 3'd3, 1'b1, 16'h5A5A, 16'h0C0C},
    '{1'b0, 16'h0, 3'd3, 1'b0, 16'h0, 3'd4, 1'b1, 3'd3, 16'h3333, 1'b1, 3'd4, 16'h4444, 3'd4, 3'd4, 1'b1, 16'h3333, 16'h4444},
    '{1'b0, 16'h0, 3'd6, 1'b1, 16'h0D0D, 3'd0, 1'b1, 3'd7, 16'h7070, 1'b1, 3'd7, 16'h7171, 3'd5, 3'd5, 1'b0, 16'h0, 16'h0},
    '{1'b1, 16'h1234, 3'd0, 1'b0, 16'h0, 3'd2, 1'b0, 3'd0, 16'h0, 1'b1, 3'd2, 16'h2020, 3'd6, 3'd6, 1'b1, 16'h1234, 16'h2020},
    '{1'b0, 16'h0, 3'd1, 1'b0, 16'h0, 3'd1, 1'b1, 3'd1, 16'h1A1A, 1'b0, 3'd0, 16'h0, 3'd7, 3'd7, 1'b1, 16'h1A1A, 16'h1A1A},
    '{1'b1, 16'hBEEF, 3'd4, 1'b1, 16'hCAFE, 3'd4, 1'b1, 3'd4, 16'hDEAD, 1'b1, 3'd4, 16'hDEAD, 3'd0, 3'd2, 1'b1, 16'hBEEF, 16'hCAFE}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic issue(input logic [2:0] op, input logic [2:0] dst,
                       input logic ar, input logic [15:0] av, input logic [2:0] at,
                       input logic br, input logic [15:0] bv, input logic [2:0] bt);
    iss_op = op; iss_dest = dst;
    iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
    iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
    iss_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [15:0] d);
    cdb_valid = 1'b1; cdb_tag = t; cdb_val = d;
    @(posedge clk); @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(disp_valid == 1'b0, "R1", "disp_valid after reset", 32'(disp_valid), 0);
    chk(iss_accept == 1'b0, "R2", "accept without request", 32'(iss_accept), 0);
    iss_valid = 1'b1; #1;
    chk(iss_accept == 1'b1, "R2", "accept into empty station", 32'(iss_accept), 1);
    iss_valid = 1'b0;

    // vector walk: R3 R4 R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      iss_op = VECS[v].op; iss_dest = VECS[v].dst;
      iss_a_rdy = VECS[v].ar; iss_a_val = VECS[v].av; iss_a_tag = VECS[v].at;
      iss_b_rdy = VECS[v].br; iss_b_val = VECS[v].bv; iss_b_tag = VECS[v].bt;
      cdb_valid = VECS[v].c1v; cdb_tag = VECS[v].c1t; cdb_val = VECS[v].c1d;
      iss_valid = 1'b1;
      #1;
      chk(iss_accept == 1'b1, "R2", $sformatf("vec %0d accept", v), 32'(iss_accept), 1);
      @(posedge clk); @(negedge clk);
      iss_valid = 1'b0;
      cdb_valid = VECS[v].c2v; cdb_tag = VECS[v].c2t; cdb_val = VECS[v].c2d;
      @(posedge clk); @(negedge clk);
      cdb_valid = 1'b0;
      #1;
      chk(disp_valid == VECS[v].xv, "R6", $sformatf("vec %0d disp_valid", v),
          32'(disp_valid), 32'(VECS[v].xv));
      if (VECS[v].xv) begin
        chk(disp_a == VECS[v].xa, "R4", $sformatf("vec %0d operand A (R3 R5)", v),
            32'(disp_a), 32'(VECS[v].xa));
        chk(disp_b == VECS[v].xb, "R4", $sformatf("vec %0d operand B (R3 R5)", v),
            32'(disp_b), 32'(VECS[v].xb));
        chk(disp_dest == VECS[v].dst && disp_op == VECS[v].op, "R6",
            $sformatf("vec %0d dest/op", v), {26'd0, disp_dest, disp_op},
            {26'd0, VECS[v].dst, VECS[v].op});
      end
      fu_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      fu_ready = 1'b0;
      if (!VECS[v].xv) begin
        flush_valid = 1'b1; flush_tag = 3'd0;
        @(posedge clk); @(negedge clk);
        flush_valid = 1'b0;
      end
      #1;
      chk(disp_valid == 1'b0, "R8", $sformatf("vec %0d emptied", v), 32'(disp_valid), 0);
    end

    // fill the pool, R2 stall, then oldest-first drain R7 R8
    @(negedge clk);
    rob_head = 3'd0;
    for (int d = 1; d <= 4; d++) issue(3'd1, 3'(d), 1'b0, 16'h0, 3'd7, 1'b1, 16'(d), 3'd0);
    iss_valid = 1'b1; #1;
    chk(iss_accept == 1'b0, "R2", "accept with pool full", 32'(iss_accept), 0);
    iss_valid = 1'b0;
    chk(disp_valid == 1'b0, "R6", "no dispatch while waiting", 32'(disp_valid), 0);
    bcast(3'd7, 16'h7777);
    #1;
    chk(disp_valid && disp_a == 16'h7777, "R4", "all slots captured tag 7", 32'(disp_a), 32'h7777);
    chk(disp_dest == 3'd1, "R7", "oldest presented first", 32'(disp_dest), 1);
    @(negedge clk);
    chk(disp_dest == 3'd1, "R8", "held while unit busy", 32'(disp_dest), 1);
    fu_ready = 1'b1;
    for (int d = 1; d <= 4; d++) begin
      #1;
      chk(disp_valid && disp_dest == 3'(d), "R7", $sformatf("drain step %0d", d), 32'(disp_dest), 32'(d));
      if (d == 2) begin
        iss_valid = 1'b1; rob_free = 1'b1; #1;
        chk(iss_accept == 1'b1, "R8", "slot freed by dispatch", 32'(iss_accept), 1);
        iss_valid = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    fu_ready = 1'b0; #1;
    chk(disp_valid == 1'b0, "R8", "pool drained", 32'(disp_valid), 0);

    // wrapped age ordering R7, reorder-full stall R2
    rob_head = 3'd6;
    issue(3'd2, 3'd1, 1'b1, 16'h0101, 3'd0, 1'b1, 16'h0, 3'd0);
    issue(3'd2, 3'd7, 1'b1, 16'h0707, 3'd0, 1'b1, 16'h0, 3'd0);
    issue(3'd2, 3'd6, 1'b1, 16'h0606, 3'd0, 1'b1, 16'h0, 3'd0);
    rob_free = 1'b0; iss_valid = 1'b1; #1;
    chk(iss_accept == 1'b0, "R2", "stall without reorder entry", 32'(iss_accept), 0);
    iss_valid = 1'b0; rob_free = 1'b1;
    fu_ready = 1'b1;
    #1;
    chk(disp_dest == 3'd6 && disp_a == 16'h0606, "R7", "wrap order first", 32'(disp_dest), 6);
    @(posedge clk); @(negedge clk); #1;
    chk(disp_dest == 3'd7, "R7", "wrap order second", 32'(disp_dest), 7);
    @(posedge clk); @(negedge clk); #1;
    chk(disp_dest == 3'd1, "R7", "wrap order third", 32'(disp_dest), 1);
    @(posedge clk); @(negedge clk);
    fu_ready = 1'b0;

    // flush R9
    rob_head = 3'd0;
    issue(3'd3, 3'd2, 1'b1, 16'h0202, 3'd0, 1'b1, 16'h0, 3'd0);
    issue(3'd3, 3'd4, 1'b0, 16'h0, 3'd7, 1'b1, 16'h0, 3'd0);
    issue(3'd3, 3'd6, 1'b0, 16'h0, 3'd7, 1'b1, 16'h0, 3'd0);
    flush_valid = 1'b1; flush_tag = 3'd4; iss_valid = 1'b1; #1;
    chk(iss_accept == 1'b0, "R9", "no issue during flush", 32'(iss_accept), 0);
    chk(disp_valid == 1'b0, "R9", "no dispatch during flush", 32'(disp_valid), 0);
    @(posedge clk); @(negedge clk);
    flush_valid = 1'b0; iss_valid = 1'b0;
    bcast(3'd7, 16'h7E7E);
    fu_ready = 1'b1; #1;
    chk(disp_dest == 3'd2, "R9", "older slot kept", 32'(disp_dest), 2);
    @(posedge clk); @(negedge clk); #1;
    chk(disp_valid && disp_dest == 3'd4 && disp_a == 16'h7E7E, "R9", "boundary slot kept",
        32'(disp_dest), 4);
    @(posedge clk); @(negedge clk); #1;
    chk(disp_valid == 1'b0, "R9", "younger slot squashed", 32'(disp_valid), 0);
    fu_ready = 1'b0;

    finish_run();
  end
endmodule